// File: doc/BRIEF.md
# Eight-Line Interrupt Controller

The block gathers eight interrupt request lines into a single interrupt output for a processor and answers the processor's acknowledge with a vector byte. A request line is latched when it rises, not while it is high. Among the latched lines that are not masked, the lowest-numbered line wins. It is presented only when it outranks every level that is already being serviced. On acknowledge, the winning line moves from pending to in-service, and its vector goes out on the read bus. That vector is a programmed base with the line number in the low three bits.

Software reaches the block through a byte bus with one address bit: a control port at address 0 and a data port at address 1. A control write with bit 4 set starts a setup sequence. The sequence then takes a base byte, then an optional cascade byte, then an optional mode byte, all on the data port. After that, data-port writes load the mask. The control port also accepts the command that closes the highest-priority in-service level. Until setup completes the interrupt output stays low.

Top module: `irq_ctrl`

## Requirements
- R1: A control-port write with bit 4 set (for example 11h) restarts setup at any time. It clears the mask, all pending requests and all in-service levels, and keeps `int_o` low until setup completes.
- R2: After the restart write, the next data-port write sets the vector base from bits 7:3 (bits 2:0 are dropped). A cascade byte follows only when the restart byte had bit 1 clear. A mode byte follows only when the restart byte had bit 0 set. Setup is then complete.
- R3: Once setup is complete, a data-port write loads the mask (bit n = 1 masks line n). A read with `rd_en_i` high returns the mask at address 1 and the pending-request byte at address 0. Otherwise `rdata_o` is 00h.
- R4: A rising edge on `irq_i[n]` sets pending bit n whether or not line n is masked. A line held high does not set it again.
- R5: Line 0 has the highest priority and line 7 the lowest. `int_o` is high exactly when setup is complete and some unmasked pending line has a lower number than every in-service level.
- R6: While `ack_i` is high with a line presented, `rdata_o` carries base | line. At that clock edge the line's in-service bit is set and its pending bit is cleared.
- R7: An acknowledge with no line presented returns base | 7 and changes no state.
- R8: After setup, a control write of 20h clears the lowest-numbered in-service bit. Other control bytes with bits 4:3 clear, such as 65h, change nothing.
- R9: A masked pending line does not raise `int_o`. It stays pending and raises `int_o` once unmasked.
- R10: After reset, `int_o` and `rdata_o` are 0 and setup is not complete.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 1 | 0 = control port, 1 = data port |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data or acknowledge vector |
| irq_i | input | 8 | Interrupt request lines |
| int_o | output | 1 | Interrupt to processor |
| ack_i | input | 1 | Interrupt acknowledge |

## Verification
The bench goes after nesting. It raises a higher line while a lower one is in service, and a design that compared priority the wrong way round would raise `int_o` for the lower line or hide the higher one. It closes levels one at a time with the 20h command. A design that cleared the wrong bit, or all of them, would let a blocked line through early, and a design that also acted on 65h would do the same. It holds a line high across an acknowledge and its close, which catches level-sensitive capture as a spurious second request. It runs a setup with single mode and a mode byte, and another with neither. A design that miscounted the setup bytes would swallow the mask write or take the mask as the base.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_BASE = 3'd1,
    ST_CASC = 3'd2,
    ST_MODE = 3'd3,
    ST_RUN  = 3'd4
  } setup_st_e;
endpackage

// File: rtl/irq_ctrl_cfg.sv
module irq_ctrl_cfg
  import irq_ctrl_pkg::*;
#(
  parameter int N_IRQ = 8,
  parameter int DW    = 8,
  localparam int LW   = $clog2(N_IRQ)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic             addr_i,
  input  logic [DW-1:0]    wdata_i,
  output logic             restart_o,
  output logic             eos_o,
  output logic             run_o,
  output logic [DW-LW-1:0] base_o,
  output logic [N_IRQ-1:0] mask_o
);
  setup_st_e           st_q;
  logic                single_q, need_mode_q;
  logic [DW-LW-1:0]    base_q;
  logic [N_IRQ-1:0]    mask_q;
  logic                data_wr;

  assign data_wr   = wr_en_i && addr_i;
  assign restart_o = wr_en_i && !addr_i && wdata_i[4];
  // non-specific close command: 001 in the top bits, bits 4:3 clear
  assign eos_o     = wr_en_i && !addr_i && (st_q == ST_RUN) &&
                     (wdata_i[7:5] == 3'b001) && (wdata_i[4:3] == 2'b00);
  assign run_o     = (st_q == ST_RUN);
  assign base_o    = base_q;
  assign mask_o    = mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_IDLE;
      single_q    <= 1'b0;
      need_mode_q <= 1'b0;
      base_q      <= '0;
      mask_q      <= '0;
    end else if (restart_o) begin
      st_q        <= ST_BASE;
      single_q    <= wdata_i[1];
      need_mode_q <= wdata_i[0];
      mask_q      <= '0;
    end else if (data_wr) begin
      unique case (st_q)
        ST_BASE: begin
          base_q <= wdata_i[DW-1:LW];
          st_q   <= !single_q ? ST_CASC : (need_mode_q ? ST_MODE : ST_RUN);
        end
        ST_CASC: st_q   <= need_mode_q ? ST_MODE : ST_RUN;
        ST_MODE: st_q   <= ST_RUN;
        ST_RUN:  mask_q <= wdata_i[N_IRQ-1:0];
        default: ;
      endcase
    end
  end

  p_restart_clears_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_o |=> (mask_q == '0) && (st_q == ST_BASE));
  p_mask_load_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_wr && st_q == ST_RUN) |=> mask_q == $past(wdata_i[N_IRQ-1:0]));
  p_base_then_run_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_wr && st_q == ST_BASE && single_q && !need_mode_q) |=> run_o);
endmodule

// File: rtl/irq_ctrl_req.sv
module irq_ctrl_req #(
  parameter int N_IRQ = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_IRQ-1:0] irq_i,
  input  logic             clr_all_i,
  input  logic [N_IRQ-1:0] ack_clr_i,
  output logic [N_IRQ-1:0] req_o
);
  logic [N_IRQ-1:0] prev_q, req_q, rise;

  assign rise  = irq_i & ~prev_q;
  assign req_o = req_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      req_q  <= '0;
    end else begin
      prev_q <= irq_i;
      // a fresh edge wins over the acknowledge clear
      req_q  <= clr_all_i ? '0 : ((req_q & ~ack_clr_i) | rise);
    end
  end

  p_edge_latched_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_all_i |=> (($past(irq_i) & ~$past(prev_q)) & ~req_q) == '0);
  p_no_spurious_set_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_all_i && ack_clr_i == '0) |=> (req_q & ~$past(req_q) & ~$past(rise)) == '0);
endmodule

// File: rtl/irq_ctrl_prio.sv
module irq_ctrl_prio #(
  parameter int N_IRQ = 8,
  localparam int LW   = $clog2(N_IRQ)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             clr_all_i,
  input  logic             eos_i,
  input  logic             ack_i,
  input  logic [N_IRQ-1:0] req_i,
  input  logic [N_IRQ-1:0] mask_i,
  output logic             present_o,
  output logic [LW-1:0]    win_o,
  output logic [N_IRQ-1:0] ack_clr_o
);
  logic [N_IRQ-1:0] srv_q, elig, eos_clr;
  logic [LW-1:0]    win, top;
  logic             found, srv_any;

  assign elig    = req_i & ~mask_i;
  assign srv_any = |srv_q;

  // downward scan leaves the lowest set index, i.e. highest priority
  always_comb begin
    win   = '0;
    found = 1'b0;
    top   = '0;
    for (int i = N_IRQ-1; i >= 0; i--) begin
      if (elig[i]) begin
        win   = LW'(i);
        found = 1'b1;
      end
      if (srv_q[i]) top = LW'(i);
    end
  end

  assign present_o = run_i && found && (!srv_any || (win < top));
  assign win_o     = win;
  assign ack_clr_o = (ack_i && present_o) ? (N_IRQ'(1) << win) : '0;
  assign eos_clr   = (eos_i && srv_any) ? (N_IRQ'(1) << top) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        srv_q <= '0;
    else if (clr_all_i) srv_q <= '0;
    else                srv_q <= (srv_q & ~eos_clr) | ack_clr_o;
  end

  p_ack_to_service_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && present_o && !clr_all_i && !eos_i) |=> srv_q[$past(win_o)]);
  p_close_one_level_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eos_i && !ack_i && !clr_all_i && srv_any) |=>
      $countones(srv_q) == $countones($past(srv_q)) - 1);
  p_spurious_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !present_o && !eos_i && !clr_all_i) |=> $stable(srv_q));
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl #(
  parameter int N_IRQ = 8,
  parameter int DW    = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic             rd_en_i,
  input  logic             addr_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [DW-1:0]    rdata_o,
  input  logic [N_IRQ-1:0] irq_i,
  output logic             int_o,
  input  logic             ack_i
);
  localparam int LW = $clog2(N_IRQ);

  logic             restart, eos, run, present;
  logic [DW-LW-1:0] base;
  logic [N_IRQ-1:0] mask, req, ack_clr;
  logic [LW-1:0]    win;

  irq_ctrl_cfg #(.N_IRQ(N_IRQ), .DW(DW)) u_cfg (
    .clk_i, .rst_ni, .wr_en_i, .addr_i, .wdata_i,
    .restart_o(restart), .eos_o(eos), .run_o(run), .base_o(base), .mask_o(mask)
  );

  irq_ctrl_req #(.N_IRQ(N_IRQ)) u_req (
    .clk_i, .rst_ni, .irq_i, .clr_all_i(restart), .ack_clr_i(ack_clr), .req_o(req)
  );

  irq_ctrl_prio #(.N_IRQ(N_IRQ)) u_prio (
    .clk_i, .rst_ni, .run_i(run), .clr_all_i(restart), .eos_i(eos), .ack_i,
    .req_i(req), .mask_i(mask), .present_o(present), .win_o(win), .ack_clr_o(ack_clr)
  );

  assign int_o = present;

  always_comb begin
    if (ack_i)        rdata_o = {base, present ? win : LW'(N_IRQ-1)};
    else if (rd_en_i) rdata_o = addr_i ? DW'(mask) : DW'(req);
    else              rdata_o = '0;
  end

  p_int_needs_run_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run |-> !int_o);
  p_masked_silent_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((req & ~mask) == '0) |-> !int_o);
endmodule

// File: tb/irq_ctrl_tb.sv
module irq_ctrl_tb;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic       wr_en = 0, rd_en = 0, addr = 0, inta = 0;
  logic [7:0] wdata = 0, irq = 0;
  logic [7:0] rdata;
  logic       int_w;
  int         checks = 0, errors = 0;
  bit         done = 0;

  always #2.5 clk = ~clk;

  irq_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .irq_i(irq), .int_o(int_w), .ack_i(inta)
  );

  // behavioural reference
  bit [7:0] m_irr = 0, m_isr = 0, m_mask = 0, m_prev = 0, m_base = 0;
  int       m_st = 0; // 0 idle,1 base,2 cascade,3 mode,4 run
  bit       m_single = 0, m_ic4 = 0;

  function automatic int m_win();
    for (int i = 0; i < 8; i++) if (m_irr[i] && !m_mask[i]) return i;
    return -1;
  endfunction
  function automatic int m_top();
    for (int i = 0; i < 8; i++) if (m_isr[i]) return i;
    return 8;
  endfunction
  function automatic bit m_present();
    int w;
    w = m_win();
    return (m_st == 4) && (w >= 0) && (w < m_top());
  endfunction
  function automatic bit [7:0] m_rdata();
    if (inta)  return m_present() ? (m_base | 8'(m_win())) : (m_base | 8'd7);
    if (rd_en) return addr ? m_mask : m_irr;
    return 8'h00;
  endfunction

  always @(posedge clk) begin
    bit [7:0] rise, ackb, eosb;
    int w, t;
    if (!rst_n) begin
      m_irr = 0; m_isr = 0; m_mask = 0; m_prev = 0; m_base = 0; m_st = 0;
      m_single = 0; m_ic4 = 0;
    end else begin
      rise = irq & ~m_prev;
      if (wr_en && !addr && wdata[4]) begin
        m_st = 1; m_single = wdata[1]; m_ic4 = wdata[0];
        m_mask = 0; m_irr = 0; m_isr = 0;
      end else begin
        w = m_win(); t = m_top(); ackb = 0; eosb = 0;
        if (inta && m_present()) ackb = 8'd1 << w;
        if (wr_en && !addr && m_st == 4 && wdata[7:5] == 3'b001 && wdata[4:3] == 2'b00 && t < 8)
          eosb = 8'd1 << t;
        m_irr = (m_irr & ~ackb) | rise;
        m_isr = (m_isr & ~eosb) | ackb;
        if (wr_en && addr) begin
          case (m_st)
            1: begin m_base = wdata & 8'hF8; m_st = !m_single ? 2 : (m_ic4 ? 3 : 4); end
            2: m_st = m_ic4 ? 3 : 4;
            3: m_st = 4;
            4: m_mask = wdata;
            default: ;
          endcase
        end
      end
      m_prev = irq;
    end
  end

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  // cycle-by-cycle comparison against the reference
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R5 int_o vs model", {7'd0, int_w}, {7'd0, m_present()});
      chk(inta ? "R6 vector vs model" : "R3 rdata vs model", rdata, m_rdata());
    end
  end

  task automatic wr(input logic a, input logic [7:0] d);
    @(posedge clk); #1; wr_en = 1; addr = a; wdata = d;
    @(posedge clk); #1; wr_en = 0; addr = 0; wdata = 0;
  endtask
  task automatic rd(input logic a, input logic [7:0] exp, input string tag);
    @(posedge clk); #1; rd_en = 1; addr = a;
    @(negedge clk); chk(tag, rdata, exp);
    @(posedge clk); #1; rd_en = 0; addr = 0;
  endtask
  task automatic ack(input logic [7:0] exp, input string tag);
    @(posedge clk); #1; inta = 1;
    @(negedge clk); chk(tag, rdata, exp);
    @(posedge clk); #1; inta = 0;
  endtask
  task automatic pulse(input logic [7:0] lines);
    @(posedge clk); #1; irq = irq | lines;
    @(posedge clk); #1; irq = irq & ~lines;
  endtask
  task automatic chk_int(input logic exp, input string tag);
    @(posedge clk); #1;
    @(negedge clk); chk(tag, {7'd0, int_w}, {7'd0, exp});
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1; errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R10 reset int_o", {7'd0, int_w}, 8'h00);
    chk("R10 reset rdata", rdata, 8'h00);
    #1 rst_n = 1;
    // cascade + mode setup, base 20h
    wr(0, 8'h11); wr(1, 8'h20); wr(1, 8'h04);
    rd(1, 8'h00, "R1 mask cleared by restart");
    wr(1, 8'h01);
    wr(1, 8'hFF); rd(1, 8'hFF, "R3 mask readback");
    pulse(8'h08);
    chk_int(0, "R9 masked line silent");
    rd(0, 8'h08, "R4 edge latched while masked");
    wr(1, 8'h00);
    chk_int(1, "R9 unmask raises int");
    ack(8'h23, "R6 vector line 3");
    chk_int(0, "R6 int drops after ack");
    rd(0, 8'h00, "R6 pending cleared");
    pulse(8'h20);
    chk_int(0, "R5 lower line blocked by service");
    pulse(8'h02);
    chk_int(1, "R5 higher line nests");
    ack(8'h21, "R6 vector line 1");
    ack(8'h27, "R7 spurious vector");
    rd(0, 8'h20, "R7 pending unchanged");
    wr(0, 8'h65);
    chk_int(0, "R8 other command ignored");
    wr(0, 8'h20);
    chk_int(0, "R8 first close leaves line 3");
    wr(0, 8'h20);
    chk_int(1, "R8 second close frees line 5");
    ack(8'h25, "R6 vector line 5");
    wr(0, 8'h20);
    // held level
    @(posedge clk); #1; irq[2] = 1'b1;
    chk_int(1, "R4 edge on line 2");
    ack(8'h22, "R6 vector line 2");
    wr(0, 8'h20);
    repeat (3) @(posedge clk);
    chk_int(0, "R4 held level not retaken");
    @(posedge clk); #1; irq[2] = 1'b0;
    pulse(8'h50);
    ack(8'h24, "R5 line 4 beats line 6");
    wr(0, 8'h20);
    ack(8'h26, "R5 line 6 next");
    wr(0, 8'h20);
    // restart mid-operation
    pulse(8'h01);
    chk_int(1, "R5 line 0 pending");
    wr(0, 8'h11);
    chk_int(0, "R1 restart drops int");
    rd(0, 8'h00, "R1 restart clears pending");
    rd(1, 8'h00, "R1 restart clears mask");
    // single mode with mode byte
    wr(0, 8'h13); wr(1, 8'h47); wr(1, 8'h01); wr(1, 8'h0F);
    rd(1, 8'h0F, "R2 no cascade byte");
    pulse(8'h20);
    ack(8'h45, "R2 base low bits dropped");
    wr(0, 8'h20);
    // single mode, no mode byte
    wr(0, 8'h12); wr(1, 8'h80); wr(1, 8'hF0);
    rd(1, 8'hF0, "R2 base then mask");
    pulse(8'h04);
    ack(8'h82, "R2 vector base 80h");
    wr(0, 8'h20);
    chk_int(0, "R8 closed");
    repeat (2) @(posedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule